// File: doc/BRIEF.md
# Replicated Multi-Read-Port RAM

A synchronous memory with a single byte-maskable write port and a parameterised number of independent read ports. Every read port has its own address and gets its own full copy of the storage. Each write goes to all copies in the same cycle, so the copies always hold the same contents. Each copy is a plain read-before-write array with one registered read. The read data of a port is ready one clock after its address is presented.

Each read port picks how it handles a read that hits the word being written in the same cycle. The mode is given by a 2-bit code per port in `MODES`, where port i uses bits [2i+1:2i]:
- code 0, read-first: the read returns the old word.
- code 1, write-first: the read returns the new data. This is built as bypass logic around the read-before-write copy.
- code 2, no-change: the port's read register holds its value while a write takes place. This applies only to the port named by `TIED_PORT`. On any other port, code 2 behaves as read-first.
- code 3: treated as read-first.

`HAS_RE` selects, per port, whether the port has a read enable. A port without one always reads and ignores its bit of `rd_en_i`. Contents are undefined until first written.

Top module: `mprt_ram`

## Requirements
- R1: Each read port returns, one clock after presenting an address with the port enabled, the stored word at that address, independently of the other ports' addresses.
- R2: Every write reaches all storage copies in the same cycle, so any two read-first ports that read the same address in the same cycle return identical data.
- R3: On a read-first port, a read of the address being written in the same cycle returns the contents from before the write.
- R4: On a write-first port, a same-cycle read of the written address returns wdata_i for every byte b (bits 8b+7:8b) whose be_i[b] is 1, and the previously stored byte for every other byte.
- R5: On the tied port in no-change mode, rdata holds its previous value after any cycle with we_i high, whatever the write and read addresses; with we_i low it reads normally.
- R6: A port configured as no-change that is not the tied port behaves exactly as read-first.
- R7: On a port that has a read enable, rd_en_i low keeps that port's read data unchanged on the next cycle, and a colliding write in that cycle is not forwarded later.
- R8: On a port configured without a read enable, its rd_en_i bit has no effect and the port reads every cycle.
- R9: While rst_ni is low, all read data outputs are zero.
- R10: A write with we_i high stores only the bytes whose be_i bit is 1; the other bytes of the word keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the read registers |
| we_i | input | 1 | Write request |
| be_i | input | DATA_W/8 | Byte write enables, bit b covers data bits 8b+7:8b |
| waddr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| raddr_i | input | N_READ*ADDR_W | Read addresses, port i in bits [i*ADDR_W +: ADDR_W] |
| rd_en_i | input | N_READ | Read enables, one bit per port, used only where HAS_RE is set |
| rdata_o | output | N_READ*DATA_W | Read data, port i in bits [i*DATA_W +: DATA_W] |

## Verification
The bench aims at same-cycle collisions on every port at once. It uses full and partial byte masks, so that:
- a read-first port that forwarded would return the new word;
- a write-first port that did not forward, or forwarded whole words, would return stale or wrong bytes.

It writes to one address while the tied no-change port reads another, which catches a design that holds only on an address match. It also places a disabled write-first port in a collision and enables it on a later quiet cycle, which exposes bypass state that updates while the port is disabled. Random traffic then forces read and write addresses to coincide about half the time.

// File: rtl/mprt_pkg.sv
package mprt_pkg;

  typedef enum logic [1:0] {
    MODE_RF = 2'd0,
    MODE_WF = 2'd1,
    MODE_NC = 2'd2
  } rd_mode_e;

  // no-change is honoured only on the tied port; code 3 and foreign no-change fall to read-first
  function automatic rd_mode_e eff_mode(input logic [1:0] code, input int idx, input int tied);
    if (code == 2'd1) return MODE_WF;
    if (code == 2'd2 && idx == tied) return MODE_NC;
    return MODE_RF;
  endfunction

endpackage

// File: rtl/mprt_bank.sv
module mprt_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int NB    = DATA_W / 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_act_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < NB; b++) begin
      if (we_i && be_i[b]) mem[waddr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  // nonblocking read of mem yields pre-write contents: read-before-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (rd_act_i) q_o <= mem[raddr_i];
  end

endmodule

// File: rtl/mprt_bypass.sv
module mprt_bypass #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [NB-1:0]     hit_r;
  logic [DATA_W-1:0] wdata_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_r   <= '0;
      wdata_r <= '0;
    end else if (en_i) begin
      hit_r   <= (we_i && raddr_i == waddr_i) ? be_i : '0;
      wdata_r <= wdata_i;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      rdata_o[b*8 +: 8] = hit_r[b] ? wdata_r[b*8 +: 8] : stored_i[b*8 +: 8];
    end
  end

endmodule

// File: rtl/mprt_port.sv
module mprt_port
  import mprt_pkg::*;
#(
  parameter int       DATA_W = 32,
  parameter int       ADDR_W = 4,
  parameter rd_mode_e MODE   = MODE_RF,
  localparam int      NB     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic              rd_act;
  logic [DATA_W-1:0] q;

  assign rd_act = en_i && !((MODE == MODE_NC) && we_i);

  mprt_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .be_i    (be_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .rd_act_i(rd_act),
    .raddr_i (raddr_i),
    .q_o     (q)
  );

  if (MODE == MODE_WF) begin : g_wf
    mprt_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_byp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .we_i    (we_i),
      .be_i    (be_i),
      .waddr_i (waddr_i),
      .raddr_i (raddr_i),
      .wdata_i (wdata_i),
      .stored_i(q),
      .rdata_o (rdata_o)
    );
  end else begin : g_direct
    assign rdata_o = q;
  end

endmodule

// File: rtl/mprt_ram.sv
module mprt_ram
  import mprt_pkg::*;
#(
  parameter int                  DATA_W    = 32,
  parameter int                  ADDR_W    = 4,
  parameter int                  N_READ    = 4,
  parameter int                  TIED_PORT = 0,
  parameter logic [2*N_READ-1:0] MODES     = 8'h26,
  parameter logic [N_READ-1:0]   HAS_RE    = 4'b1011,
  localparam int                 NB        = DATA_W / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [NB-1:0]            be_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [N_READ*ADDR_W-1:0] raddr_i,
  input  logic [N_READ-1:0]        rd_en_i,
  output logic [N_READ*DATA_W-1:0] rdata_o
);

  logic [N_READ-1:0] port_en;
  logic              unused_en;

  // enable bits of ports built without an enable are not used
  assign unused_en = ^(rd_en_i & ~HAS_RE);

  for (genvar g = 0; g < N_READ; g++) begin : g_port
    if (HAS_RE[g]) begin : g_re
      assign port_en[g] = rd_en_i[g];
    end else begin : g_no_re
      assign port_en[g] = 1'b1;
    end

    mprt_port #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .MODE  (eff_mode(MODES[2*g +: 2], g, TIED_PORT))
    ) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_i),
      .be_i   (be_i),
      .waddr_i(waddr_i),
      .wdata_i(wdata_i),
      .en_i   (port_en[g]),
      .raddr_i(raddr_i[g*ADDR_W +: ADDR_W]),
      .rdata_o(rdata_o[g*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/mprt_ram_chk.sv
module mprt_ram_chk
  import mprt_pkg::*;
#(
  parameter int                  DATA_W    = 32,
  parameter int                  ADDR_W    = 4,
  parameter int                  N_READ    = 4,
  parameter int                  TIED_PORT = 0,
  parameter logic [2*N_READ-1:0] MODES     = 8'h26,
  parameter logic [N_READ-1:0]   HAS_RE    = 4'b1011,
  localparam int                 NB        = DATA_W / 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     we_i,
  input logic [NB-1:0]            be_i,
  input logic [ADDR_W-1:0]        waddr_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic [N_READ*ADDR_W-1:0] raddr_i,
  input logic [N_READ-1:0]        rd_en_i,
  input logic [N_READ*DATA_W-1:0] rdata_o
);

  logic [N_READ-1:0] en_c;
  logic [ADDR_W-1:0] ra_a [N_READ];
  logic [DATA_W-1:0] rd_a [N_READ];

  for (genvar i = 0; i < N_READ; i++) begin : g_p
    localparam rd_mode_e M = eff_mode(MODES[2*i +: 2], i, TIED_PORT);
    assign en_c[i] = HAS_RE[i] ? rd_en_i[i] : 1'b1;
    assign ra_a[i] = raddr_i[i*ADDR_W +: ADDR_W];
    assign rd_a[i] = rdata_o[i*DATA_W +: DATA_W];

    if (HAS_RE[i]) begin : g_re
      p_hold_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i[i] |=> $stable(rd_a[i]));
    end

    if (M == MODE_NC) begin : g_nc
      p_nochange_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> $stable(rd_a[i]));
    end

    if (M == MODE_WF) begin : g_wf
      p_wf_forward_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (&be_i) && en_c[i] && ra_a[i] == waddr_i) |=> rd_a[i] == $past(wdata_i));
    end

    for (genvar j = i + 1; j < N_READ; j++) begin : g_pair
      if (M == MODE_RF && eff_mode(MODES[2*j +: 2], j, TIED_PORT) == MODE_RF) begin : g_rf
        p_copies_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (en_c[i] && en_c[j] && ra_a[i] == ra_a[j]) |=> rd_a[i] == rd_a[j]);
      end
    end
  end

endmodule

bind mprt_ram mprt_ram_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .N_READ   (N_READ),
  .TIED_PORT(TIED_PORT),
  .MODES    (MODES),
  .HAS_RE   (HAS_RE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .be_i   (be_i),
  .waddr_i(waddr_i),
  .wdata_i(wdata_i),
  .raddr_i(raddr_i),
  .rd_en_i(rd_en_i),
  .rdata_o(rdata_o)
);

// File: tb/mprt_ram_tb.sv
module mprt_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NR = 4;
  // port 0: no-change (tied), port 1: write-first, port 2: no-change code on a non-tied port, port 3: read-first
  localparam int         MD  [NR] = '{2, 1, 0, 0};
  localparam bit         HRE [NR] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam string      PTAG[NR] = '{"R5", "R4", "R6", "R3"};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [3:0]        be_i = '0;
  logic [AW-1:0]     waddr_i = '0;
  logic [DW-1:0]     wdata_i = '0;
  logic [NR*AW-1:0]  raddr_i = '0;
  logic [NR-1:0]     rd_en_i = '0;
  logic [NR*DW-1:0]  rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [16];
  logic [DW-1:0] exp_q [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  mprt_ram u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .be_i   (be_i),
    .waddr_i(waddr_i),
    .wdata_i(wdata_i),
    .raddr_i(raddr_i),
    .rd_en_i(rd_en_i),
    .rdata_o(rdata_o)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag, input int port);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port %0d: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  // drive at negedge, model the edge, sample after it
  task automatic step(input logic we, input logic [3:0] be, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [NR*AW-1:0] ra,
                      input logic [NR-1:0] en, input string tag, input bit do_chk);
    we_i = we; be_i = be; waddr_i = wa; wdata_i = wd; raddr_i = ra; rd_en_i = en;
    for (int i = 0; i < NR; i++) begin
      logic pen;
      logic [DW-1:0] d;
      logic [AW-1:0] a;
      pen = HRE[i] ? en[i] : 1'b1;
      a = ra[i*AW +: AW];
      if (pen && !(MD[i] == 2 && we)) begin
        d = ref_mem[a];
        if (MD[i] == 1 && we && a == wa)
          for (int b = 0; b < 4; b++) if (be[b]) d[b*8 +: 8] = wd[b*8 +: 8];
        exp_q[i] = d;
      end
    end
    if (we) for (int b = 0; b < 4; b++) if (be[b]) ref_mem[wa][b*8 +: 8] = wd[b*8 +: 8];
    @(posedge clk);
    #1;
    if (do_chk)
      for (int i = 0; i < NR; i++)
        check(rdata_o[i*DW +: DW], exp_q[i], (tag == "") ? PTAG[i] : tag, i);
    @(negedge clk);
  endtask

  function automatic logic [NR*AW-1:0] all_ra(input logic [AW-1:0] a);
    return {NR{a}};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < NR; i++) exp_q[i] = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NR; i++) check(rdata_o[i*DW +: DW], '0, "R9", i);
    rst_ni = 1'b1;
    @(negedge clk);

    // fill every word, no checks while contents are undefined
    for (int k = 0; k < 16; k++)
      step(1'b1, 4'hf, AW'(k), 32'hA000_0000 + 32'(k) * 32'h0101_0101, all_ra(AW'(15)), '0, "", 1'b0);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(1)), 4'hf, "R1", 1'b1);

    // full-word collision on every port: per-port mode tags
    step(1'b1, 4'hf, AW'(5), 32'hDEAD_BEEF, all_ra(AW'(5)), 4'hf, "", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(5)), 4'hf, "R1", 1'b1);
    // partial-mask collision
    step(1'b1, 4'b0011, AW'(7), 32'h1122_3344, all_ra(AW'(7)), 4'hf, "", 1'b1);
    // partial write then plain read
    step(1'b1, 4'b0101, AW'(6), 32'hCAFE_F00D, all_ra(AW'(2)), 4'hf, "R10", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(6)), 4'hf, "R10", 1'b1);
    // tied no-change port holds on a write elsewhere
    step(1'b1, 4'hf, AW'(9), 32'h9999_0000, {AW'(3), AW'(3), AW'(3), AW'(3)}, 4'hf, "R5", 1'b1);
    step(1'b0, 4'h0, '0, '0, {AW'(9), AW'(9), AW'(9), AW'(4)}, 4'hf, "R5", 1'b1);
    // disabled ports during a collision, then a quiet enabled read of another word
    step(1'b1, 4'hf, AW'(3), 32'h3333_3333, all_ra(AW'(3)), 4'h0, "R7", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(3)), 4'h0, "R7", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(8)), 4'hf, "R7", 1'b1);
    // port without enable ignores its bit
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(10)), 4'b1011, "R8", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(11)), 4'b0000, "R8", 1'b1);
    // copies agree
    step(1'b1, 4'hf, AW'(12), 32'h0BAD_CAFE, all_ra(AW'(13)), 4'hf, "R2", 1'b1);
    step(1'b0, 4'h0, '0, '0, all_ra(AW'(12)), 4'hf, "R2", 1'b1);
    // independent addresses
    step(1'b0, 4'h0, '0, '0, {AW'(14), AW'(12), AW'(6), AW'(5)}, 4'hf, "R1", 1'b1);

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa;
      logic [NR*AW-1:0] ra;
      wa = AW'($urandom % 16);
      for (int i = 0; i < NR; i++) ra[i*AW +: AW] = ($urandom % 2) ? wa : AW'($urandom % 16);
      step(1'($urandom % 2), 4'($urandom), wa, $urandom, ra, NR'($urandom), "", 1'b1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule